// File: doc/BRIEF.md
# Class-D Bridge Gate Controller

This block turns two 1-bit audio streams (pulse-width or pulse-density modulated) into gate enables for two full-bridge output stages. Each channel owns one bridge with a true leg and a complement leg, and every leg gets its own high-side and low-side enable. An external power stage and its output filter turn these enables into the analog signal.

Three controls set the output state, in strict priority. An active-low halt pulls every leg to the low rail. An active-low standby, when halt is inactive, turns both switches of every leg off so that the outputs float. Otherwise the audio data steers the bridges. A select input chooses how the data arrives. In one mode each stream is captured on rising edges of a master clock, which the system clock samples. In the other mode the streams feed the bridge logic directly.

Every leg runs a break-before-make sequencer on the system clock. Whenever a leg is about to change which side conducts, it first turns both switches off and waits for a programmable dead time.

Top module: `bridge_gate_ctrl`

## Requirements
- R1: Each leg reports a code {high-side enable, low-side enable}: 10 means driven to the high rail, 01 means the low rail and 00 means both off. Code 11 never appears. The legs are indexed 0 = channel 1 true, 1 = channel 1 complement, 2 = channel 2 true, 3 = channel 2 complement.
- R2: With `sel_sync` high, a channel's data is taken from `din` only when a rising edge of `mck` is seen by the system clock. Changes on `din` at any other time, including while `mck` stays high, have no effect on the legs.
- R3: With `sel_sync` low, `din` drives the legs without a capture register. With zero dead time, a new data value shows at the legs two system-clock edges after it is applied.
- R4: While `halt_n` is low, every leg settles to code 01, whatever the values of `stby_n`, `sel_sync` and the data. Every high-side enable is off from the first clock edge after halt is asserted.
- R5: While `halt_n` is high and `stby_n` is low, every leg shows code 00 from the first clock edge on.
- R6: In normal operation, data 1 puts a channel's true leg at 10 and its complement leg at 01. Data 0 gives the reverse.
- R7: Channel 1 data affects only legs 0 and 1, and channel 2 data affects only legs 2 and 3.
- R8: When a leg reverses direction, it shows code 00 for exactly `dead_cfg` + 1 system-clock cycles before the new side turns on. It never goes straight from 10 to 01 or from 01 to 10.
- R9: When halt is asserted, a leg at 10 reaches 01 after exactly `dead_cfg` + 1 cycles at 00.
- R10: While `rst` is high, every leg is held at 01 and both capture registers clear to 0. Both take effect at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mck | input | 1 | Master clock for data capture, sampled by `clk` |
| sel_sync | input | 1 | 1: capture data on `mck` rising edges; 0: pass data through |
| halt_n | input | 1 | Active-low halt; all legs go to the low rail |
| stby_n | input | 1 | Active-low standby; all legs are switched off |
| din | input | NUM_CH (2) | 1-bit audio streams, bit 0 = channel 1 |
| dead_cfg | input | DT_W (4) | Dead time in system-clock cycles, added to the single switch-off cycle |
| hs_en | output | 2*NUM_CH (4) | High-side gate enable per leg |
| ls_en | output | 2*NUM_CH (4) | Low-side gate enable per leg |

## Verification
The bench uses the default parameters, two channels and a 4-bit dead-time field, so all four legs and every dead-time value are in reach. It sets `dead_cfg` to 0, 3 and 15, which covers the minimum switch-off interval, a mid value and the full count of the counter. At dead time 0 it also measures the pass-through latency cycle by cycle. The truth table runs through all 32 combinations of halt, standby, select and the two data bits.

// File: rtl/bridge_gate_pkg.sv
package bridge_gate_pkg;

    // Encoding matches {high-side enable, low-side enable}.
    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOW  = 2'b01,
        DRV_HIGH = 2'b10
    } drive_e;

    // Priority: halt over standby over data. Complement legs invert the data.
    function automatic drive_e leg_target(
        input logic halt_n,
        input logic stby_n,
        input logic data,
        input logic complement
    );
        if (!halt_n)
            return DRV_LOW;
        else if (!stby_n)
            return DRV_OFF;
        else if (data ^ complement)
            return DRV_HIGH;
        else
            return DRV_LOW;
    endfunction

endpackage

// File: rtl/bridge_din_path.sv
module bridge_din_path #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mck,
    input  logic              sel_sync,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] data_sel
);

    logic              mck_q;
    logic [NUM_CH-1:0] cap_q;
    logic              mck_rise;

    assign mck_rise = mck && !mck_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mck_q <= 1'b0;
            cap_q <= '0;
        end else begin
            mck_q <= mck;
            if (mck_rise)
                cap_q <= din;
        end
    end

    assign data_sel = sel_sync ? cap_q : din;

endmodule

// File: rtl/bridge_leg_ctrl.sv
module bridge_leg_ctrl
    import bridge_gate_pkg::*;
#(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DT_W-1:0] dead_cfg,
    input  drive_e          target,
    output drive_e          state
);

    drive_e          cur_q;
    logic [DT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= DRV_LOW;
            wait_q <= '0;
        end else if (cur_q != DRV_OFF) begin
            // Any change leaves a driven state through OFF first.
            if (target != cur_q) begin
                cur_q  <= DRV_OFF;
                wait_q <= dead_cfg;
            end
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end else if (target != DRV_OFF) begin
            cur_q <= target;
        end
    end

    assign state = cur_q;

endmodule

// File: rtl/bridge_gate_ctrl.sv
module bridge_gate_ctrl
    import bridge_gate_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DT_W   = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mck,
    input  logic                  sel_sync,
    input  logic                  halt_n,
    input  logic                  stby_n,
    input  logic [NUM_CH-1:0]     din,
    input  logic [DT_W-1:0]       dead_cfg,
    output logic [2*NUM_CH-1:0]   hs_en,
    output logic [2*NUM_CH-1:0]   ls_en
);

    localparam int NUM_LEGS = 2 * NUM_CH;

    logic [NUM_CH-1:0] data_sel;

    bridge_din_path #(.NUM_CH(NUM_CH)) u_din (
        .clk      (clk),
        .rst      (rst),
        .mck      (mck),
        .sel_sync (sel_sync),
        .din      (din),
        .data_sel (data_sel)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar pol = 0; pol < 2; pol++) begin : g_leg
            localparam int LEG = 2 * ch + pol;
            drive_e tgt;
            drive_e st;

            assign tgt = leg_target(halt_n, stby_n, data_sel[ch], pol[0]);

            bridge_leg_ctrl #(.DT_W(DT_W)) u_leg (
                .clk      (clk),
                .rst      (rst),
                .dead_cfg (dead_cfg),
                .target   (tgt),
                .state    (st)
            );

            assign hs_en[LEG] = st[1];
            assign ls_en[LEG] = st[0];
        end
    end

endmodule

// File: rtl/bridge_gate_ctrl_chk.sv
module bridge_gate_ctrl_chk #(
    parameter int NUM_LEGS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                halt_n,
    input logic                stby_n,
    input logic [NUM_LEGS-1:0] hs_en,
    input logic [NUM_LEGS-1:0] ls_en
);

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (hs_en & ls_en) == '0); // R1

    AST_HALT_HS_OFF: assert property (@(posedge clk) disable iff (rst)
        !halt_n |=> hs_en == '0); // R4

    AST_STBY_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (halt_n && !stby_n) |=> (hs_en | ls_en) == '0); // R5

    AST_NO_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(hs_en) & ls_en) == '0); // R8

    AST_NO_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($past(ls_en) & hs_en) == '0); // R8

    AST_RESET_ALL_LOW: assert property (@(posedge clk)
        rst |=> (hs_en == '0 && ls_en == '1)); // R10

endmodule

bind bridge_gate_ctrl bridge_gate_ctrl_chk #(.NUM_LEGS(2 * NUM_CH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .halt_n (halt_n),
    .stby_n (stby_n),
    .hs_en  (hs_en),
    .ls_en  (ls_en)
);

// File: tb/tb_bridge_gate_ctrl.sv
module tb_bridge_gate_ctrl;

    localparam int NUM_CH = 2;
    localparam int DT_W   = 4;
    localparam int NL     = 2 * NUM_CH;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            mck = 1'b0;
    logic            sel_sync = 1'b0;
    logic            halt_n = 1'b1;
    logic            stby_n = 1'b1;
    logic [NUM_CH-1:0] din = '0;
    logic [DT_W-1:0] dead_cfg = '0;
    logic [NL-1:0]   hs_en;
    logic [NL-1:0]   ls_en;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    bridge_gate_ctrl #(.NUM_CH(NUM_CH), .DT_W(DT_W)) dut (
        .clk(clk), .rst(rst), .mck(mck), .sel_sync(sel_sync),
        .halt_n(halt_n), .stby_n(stby_n), .din(din), .dead_cfg(dead_cfg),
        .hs_en(hs_en), .ls_en(ls_en)
    );

    function automatic logic [1:0] code(input int l);
        return {hs_en[l], ls_en[l]};
    endfunction

    function automatic logic [7:0] all_codes();
        return {code(3), code(2), code(1), code(0)};
    endfunction

    function automatic logic [7:0] expect_all(input logic h, input logic s, input logic [1:0] d);
        logic [7:0] e;
        for (int l = 0; l < NL; l++) begin
            logic [1:0] c;
            if (!h)                     c = 2'b01;
            else if (!s)                c = 2'b00;
            else if (d[l/2] ^ l[0])     c = 2'b10;
            else                        c = 2'b01;
            e[2*l +: 2] = c;
        end
        return e;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    task automatic pulse_mck();
        @(negedge clk) mck = 1'b1;
        repeat (2) @(negedge clk);
        mck = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 legs low in reset", all_codes(), 8'b01010101);
        // capture a 11 pattern, then reset must clear it
        @(negedge clk) rst = 1'b0;
        sel_sync = 1'b1; din = 2'b11;
        pulse_mck();
        settle();
        check("R10 pre-reset capture", all_codes(), expect_all(1, 1, 2'b11));
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R10 legs low in reset (2)", all_codes(), 8'b01010101);
        rst = 1'b0;
        settle();
        check("R10 capture regs cleared", all_codes(), expect_all(1, 1, 2'b00));
    endtask

    task automatic t_truth_table();
        dead_cfg = 4'd3;
        for (int h = 0; h < 2; h++)
            for (int s = 0; s < 2; s++)
                for (int sl = 0; sl < 2; sl++)
                    for (int d = 0; d < 4; d++) begin
                        @(negedge clk);
                        halt_n = h[0]; stby_n = s[0]; sel_sync = sl[0]; din = d[1:0];
                        if (sl != 0) pulse_mck();
                        settle();
                        check($sformatf("R4 R5 R6 R1 h=%0d s=%0d sel=%0d d=%0d", h, s, sl, d),
                              all_codes(), expect_all(h[0], s[0], d[1:0]));
                    end
        halt_n = 1'b1; stby_n = 1'b1;
    endtask

    task automatic t_sync_mode();
        dead_cfg = 4'd2;
        @(negedge clk) sel_sync = 1'b1; din = 2'b00;
        pulse_mck(); settle();
        @(negedge clk) din = 2'b11;
        settle();
        check("R2 no mck edge ignored", all_codes(), expect_all(1, 1, 2'b00));
        @(negedge clk) mck = 1'b1;
        settle();
        check("R2 capture on mck rise", all_codes(), expect_all(1, 1, 2'b11));
        @(negedge clk) din = 2'b01;
        settle();
        check("R2 mck held high ignored", all_codes(), expect_all(1, 1, 2'b11));
        @(negedge clk) mck = 1'b0;
        settle();
        check("R2 mck fall ignored", all_codes(), expect_all(1, 1, 2'b11));
        pulse_mck(); settle();
        check("R2 next rise captures", all_codes(), expect_all(1, 1, 2'b01));
    endtask

    task automatic t_async_mode();
        dead_cfg = 4'd0;
        @(negedge clk) sel_sync = 1'b0; mck = 1'b0; din = 2'b00;
        settle();
        @(negedge clk) din = 2'b11;
        @(negedge clk);
        check("R3 one cycle off", all_codes(), 8'b00000000);
        @(negedge clk);
        check("R3 two-edge latency", all_codes(), expect_all(1, 1, 2'b11));
        @(negedge clk) din = 2'b10;
        settle();
        check("R3 pass-through", all_codes(), expect_all(1, 1, 2'b10));
    endtask

    task automatic t_channel_indep();
        int bad = 0;
        logic [3:0] ref_lo;
        dead_cfg = 4'd1;
        @(negedge clk) sel_sync = 1'b0; din = 2'b01;
        settle();
        ref_lo = all_codes()[3:0];
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i % 8 == 0) din[1] = ~din[1];
            if (all_codes()[3:0] !== ref_lo) bad++;
        end
        n_checks++;
        if (bad != 0) begin
            n_errors++;
            $display("FAIL R7 ch2 data moved ch1 legs: actual %0d changes expected 0", bad);
        end
        din[1] = 1'b0; din[0] = 1'b1;
        settle();
        ref_lo = all_codes()[7:4];
        @(negedge clk) din[0] = 1'b0;
        settle();
        check("R7 ch1 data leaves ch2 legs", {4'b0, all_codes()[7:4]}, {4'b0, ref_lo});
    endtask

    task automatic t_dead_time(input int dt);
        int off0 = 0, off1 = 0, n = 0, bad11 = 0;
        dead_cfg = dt[DT_W-1:0];
        @(negedge clk) sel_sync = 1'b0; halt_n = 1'b1; stby_n = 1'b1; din = 2'b00;
        settle();
        @(negedge clk) din = 2'b01;
        while (n < 60) begin
            @(negedge clk); n++;
            if (code(0) == 2'b00) off0++;
            if (code(1) == 2'b00) off1++;
            if (code(0) == 2'b11 || code(1) == 2'b11) bad11++;
            if (code(0) == 2'b10 && code(1) == 2'b01) break;
        end
        check($sformatf("R8 leg0 off cycles dt=%0d", dt), 8'(off0), 8'(dt + 1));
        check($sformatf("R8 leg1 off cycles dt=%0d", dt), 8'(off1), 8'(dt + 1));
        check("R1 no code 11 during swap", 8'(bad11), 8'd0);
        // halt entry from leg0 high
        off0 = 0; n = 0;
        @(negedge clk) halt_n = 1'b0;
        while (n < 60) begin
            @(negedge clk); n++;
            if (code(0) == 2'b00) off0++;
            if (all_codes() == 8'b01010101) break;
        end
        check($sformatf("R9 halt off cycles dt=%0d", dt), 8'(off0), 8'(dt + 1));
        check($sformatf("R9 halt reach cycles dt=%0d", dt), 8'(n), 8'(dt + 2));
        // standby entry
        @(negedge clk) halt_n = 1'b1;
        settle();
        @(negedge clk) stby_n = 1'b0;
        @(negedge clk);
        check($sformatf("R5 standby next edge dt=%0d", dt), all_codes(), 8'b00000000);
        stby_n = 1'b1;
        settle();
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        t_reset();
        t_async_mode();
        t_sync_mode();
        t_channel_indep();
        t_dead_time(0);
        t_dead_time(3);
        t_dead_time(15);
        t_truth_table();
        finish_sim();
    end

endmodule